// File: doc/BRIEF.md
# Prioritised Level-Interrupt Controller

This block gathers 64 level-sensitive request lines, masks each line with a per-line enable and gives each line a 4-bit priority. The line that wins arbitration is presented to the processor as an interrupt request, together with the winner's event code and its priority level. Software reaches the block through a simple register bus with one-cycle writes and registered reads.

The enables are never written directly. One register per bank turns on every line whose data bit is 1. A second register per bank turns off every line whose data bit is 1. Two drivers can therefore change different lines without a read-modify-write. The single mode bit works the same way, through its own set and clear addresses. Each 32-bit priority register carries eight 4-bit fields.

Each line's event code is computed from its index. The line's vector number is `VEC_BASE` plus the line index, and the code is that vector number times 0x20. With the default base, line 0 gives code 0x240.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, all enables are 0, all priorities are 0, the mode bit is 0, `irq_o` is 0 and every status readback is 0.
- R2: A write to offset 0x70 (lines 0–31) or 0x78 (lines 32–63) sets the enable of every line whose data bit is 1. Line n uses bit n mod 32. Lines whose data bit is 0 keep their enable. Offsets 0x70 and 0x78 read back the current enables.
- R3: A write to offset 0x80 (low bank) or 0x88 (high bank) clears the enable of every line whose data bit is 1. Writing all ones clears the whole bank. These offsets read as 0.
- R4: A write with data bit 0 set to offset 0x00 sets the mode bit. The same write to offset 0x08 clears it. A write whose bit 0 is 0 leaves the mode bit unchanged. Reads of either offset return the mode bit in bit 0.
- R5: The priority register for group k is at offset 0x10 + 8k, for k = 0..7, and it reads back as written. Line i takes its priority from bits [4*(i mod 8)+3 : 4*(i mod 8)] of register i/8.
- R6: Offsets 0x50/0x58 read the latched raw inputs of the low and high bank. Offsets 0x60/0x68 read the latched inputs ANDed with the enables.
- R7: A line with priority 0 never wins, even when it is enabled and pending.
- R8: Among lines that are latched-pending, enabled and of nonzero priority, the winner is the line with the largest priority value. A tie goes to the lowest line index.
- R9: While a winner exists, `level_o` equals the winner's priority and `vec_o` equals (0x12 + index) × 0x20.
- R10: `irq_o` is 1 exactly when a winner exists. When there is no winner, `level_o` and `vec_o` are 0. An input change is latched at one clock edge, and the outputs reflect it at the next edge. A register write takes effect on the outputs one edge after the write edge.
- R11: Read data appears on `bus_rdata` after the clock edge at which `bus_re` is sampled. It holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | 64 | Level-sensitive request lines |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request to the processor |
| level_o | output | 4 | Priority of the winning line |
| vec_o | output | 12 | Event code of the winning line |

## Verification
Directed patterns drive single lines to show each line's bank bit, priority field and event code. Two equal-priority lines show whether ties go to the lower index. A high-priority line with its enable off, and an enabled pending line at priority 0, show whether masking and the zero-priority rule are applied. Random enable words, priority words and 64-bit request patterns are then compared against a bench model of the arbitration. A cycle-exact check of a single request separates the latch edge from the output edge.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  // Register byte offsets on the local bus
  localparam int unsigned OFF_CTRL_SET = 'h00;
  localparam int unsigned OFF_CTRL_CLR = 'h08;
  localparam int unsigned OFF_PRIO     = 'h10;
  localparam int unsigned OFF_SRC      = 'h50;
  localparam int unsigned OFF_REQ      = 'h60;
  localparam int unsigned OFF_ENB      = 'h70;
  localparam int unsigned OFF_DSB      = 'h80;
  localparam int unsigned REG_STRIDE   = 8;
  localparam int unsigned CODE_SHIFT   = 5;   // code = vector * 0x20
endpackage

// File: rtl/pirq_regs.sv
module pirq_regs
  import pirq_pkg::*;
#(
  parameter int unsigned N_LINES = 64,
  parameter int unsigned PRIO_W  = 4,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic                      re,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  output logic [DATA_W-1:0]         rdata,
  input  logic [N_LINES-1:0]        src,
  output logic [N_LINES-1:0]        en,
  output logic [N_LINES*PRIO_W-1:0] prio,
  output logic                      mode
);
  localparam int unsigned BANKS = N_LINES / DATA_W;
  localparam int unsigned FPR   = DATA_W / PRIO_W;
  localparam int unsigned PREGS = N_LINES / FPR;

  logic [N_LINES-1:0]        en_q;
  logic [N_LINES*PRIO_W-1:0] prio_q;
  logic                      mode_q;
  logic [DATA_W-1:0]         rd_next;

  // Enable banks: set and clear aliases per bank
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    localparam logic [ADDR_W-1:0] A_ENB = ADDR_W'(OFF_ENB + REG_STRIDE * b);
    localparam logic [ADDR_W-1:0] A_DSB = ADDR_W'(OFF_DSB + REG_STRIDE * b);
    always_ff @(posedge clk) begin
      if (rst)
        en_q[b*DATA_W +: DATA_W] <= '0;
      else if (we && addr == A_ENB)
        en_q[b*DATA_W +: DATA_W] <= en_q[b*DATA_W +: DATA_W] | wdata;
      else if (we && addr == A_DSB)
        en_q[b*DATA_W +: DATA_W] <= en_q[b*DATA_W +: DATA_W] & ~wdata;
    end
  end

  // Priority registers: packed fields, line i at [i*PRIO_W +: PRIO_W]
  for (genvar k = 0; k < PREGS; k++) begin : g_prio
    localparam logic [ADDR_W-1:0] A_PRI = ADDR_W'(OFF_PRIO + REG_STRIDE * k);
    always_ff @(posedge clk) begin
      if (rst)
        prio_q[k*DATA_W +: DATA_W] <= '0;
      else if (we && addr == A_PRI)
        prio_q[k*DATA_W +: DATA_W] <= wdata;
    end
  end

  // Mode bit with set / clear aliases
  always_ff @(posedge clk) begin
    if (rst)
      mode_q <= 1'b0;
    else if (we && addr == ADDR_W'(OFF_CTRL_SET) && wdata[0])
      mode_q <= 1'b1;
    else if (we && addr == ADDR_W'(OFF_CTRL_CLR) && wdata[0])
      mode_q <= 1'b0;
  end

  // Read multiplexer
  always_comb begin
    rd_next = '0;
    if (addr == ADDR_W'(OFF_CTRL_SET) || addr == ADDR_W'(OFF_CTRL_CLR))
      rd_next = DATA_W'(mode_q);
    for (int b = 0; b < BANKS; b++) begin
      if (addr == ADDR_W'(OFF_SRC + REG_STRIDE * b))
        rd_next = src[b*DATA_W +: DATA_W];
      if (addr == ADDR_W'(OFF_REQ + REG_STRIDE * b))
        rd_next = src[b*DATA_W +: DATA_W] & en_q[b*DATA_W +: DATA_W];
      if (addr == ADDR_W'(OFF_ENB + REG_STRIDE * b))
        rd_next = en_q[b*DATA_W +: DATA_W];
    end
    for (int k = 0; k < PREGS; k++) begin
      if (addr == ADDR_W'(OFF_PRIO + REG_STRIDE * k))
        rd_next = prio_q[k*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (re)
      rdata <= rd_next;
  end

  assign en   = en_q;
  assign prio = prio_q;
  assign mode = mode_q;
endmodule

// File: rtl/pirq_arb.sv
module pirq_arb #(
  parameter int unsigned N_LINES = 64,
  parameter int unsigned PRIO_W  = 4,
  parameter int unsigned IDX_W   = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0]        req,
  input  logic [N_LINES*PRIO_W-1:0] prio,
  output logic                      found,
  output logic [IDX_W-1:0]          win_idx,
  output logic [PRIO_W-1:0]         win_prio
);
  logic [N_LINES-1:0] elig;

  for (genvar i = 0; i < N_LINES; i++) begin : g_elig
    assign elig[i] = req[i] && (prio[i*PRIO_W +: PRIO_W] != '0);
  end

  // Scan from the top index down; ">=" lets a lower index take a tie
  always_comb begin
    found    = 1'b0;
    win_idx  = '0;
    win_prio = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (elig[i] && prio[i*PRIO_W +: PRIO_W] >= win_prio) begin
        found    = 1'b1;
        win_idx  = IDX_W'(i);
        win_prio = prio[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pirq_pkg::*;
#(
  parameter int unsigned N_LINES  = 64,
  parameter int unsigned PRIO_W   = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned CODE_W   = 12,
  parameter int unsigned VEC_BASE = 'h12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_i,
  input  logic               bus_we,
  input  logic               bus_re,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_o,
  output logic [PRIO_W-1:0]  level_o,
  output logic [CODE_W-1:0]  vec_o
);
  localparam int unsigned IDX_W = $clog2(N_LINES);

  logic [N_LINES-1:0]        src_q;
  logic [N_LINES-1:0]        en_w;
  logic [N_LINES*PRIO_W-1:0] prio_w;
  logic                      mode_w;
  logic                      found;
  logic [IDX_W-1:0]          win_idx;
  logic [PRIO_W-1:0]         win_prio;
  logic [CODE_W-1:0]         code;

  always_ff @(posedge clk) begin
    if (rst) src_q <= '0;
    else     src_q <= irq_i;
  end

  pirq_regs #(
    .N_LINES(N_LINES), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .re(bus_re), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .src(src_q),
    .en(en_w), .prio(prio_w), .mode(mode_w)
  );

  pirq_arb #(
    .N_LINES(N_LINES), .PRIO_W(PRIO_W), .IDX_W(IDX_W)
  ) u_arb (
    .req(src_q & en_w), .prio(prio_w),
    .found(found), .win_idx(win_idx), .win_prio(win_prio)
  );

  assign code = (CODE_W'(VEC_BASE) + CODE_W'(win_idx)) << CODE_SHIFT;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o   <= 1'b0;
      level_o <= '0;
      vec_o   <= '0;
    end else begin
      irq_o   <= found;
      level_o <= found ? win_prio : '0;
      vec_o   <= found ? code : '0;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int unsigned N_LINES = 64,
  parameter int unsigned PRIO_W  = 4,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned CODE_W  = 12
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_we,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [N_LINES-1:0] en,
  input logic               mode,
  input logic               irq_o,
  input logic [PRIO_W-1:0]  level_o,
  input logic [CODE_W-1:0]  vec_o
);
  // R1: outputs quiet in the first cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_o && en == '0 && !mode));

  // R2: enable write sets every selected low-bank line
  p_enable_set_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'('h70)) |=>
      ((en[DATA_W-1:0] & $past(bus_wdata)) == $past(bus_wdata)));

  // R3: disable write clears every selected high-bank line
  p_disable_clr_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'('h88)) |=>
      ((en[N_LINES-1 -: DATA_W] & $past(bus_wdata)) == '0));

  // R4: set alias raises the mode bit, clear alias drops it
  p_mode_set_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'('h00) && bus_wdata[0]) |=> mode);
  p_mode_clr_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'('h08) && bus_wdata[0]) |=> !mode);

  // R7: a granted request never carries level 0
  p_level_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (level_o != '0));

  // R9: granted code is 0x20-aligned and at or above the base code
  p_code_shape_r9: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (vec_o[4:0] == '0 && vec_o >= CODE_W'('h240)));

  // R10: without a request the level and code read zero
  p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !irq_o |-> (level_o == '0 && vec_o == '0));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
  .N_LINES(N_LINES), .PRIO_W(PRIO_W), .DATA_W(DATA_W),
  .ADDR_W(ADDR_W), .CODE_W(CODE_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .en(en_w), .mode(mode_w),
  .irq_o(irq_o), .level_o(level_o), .vec_o(vec_o)
);

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] irq_i = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  logic [3:0]  level_o;
  logic [11:0] vec_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // bench model
  logic [63:0]  m_en   = '0;
  logic [255:0] m_prio = '0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rst(rst), .irq_i(irq_i), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .level_o(level_o), .vec_o(vec_o)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    if (a == 8'h70) m_en[31:0]  = m_en[31:0]  | d;
    if (a == 8'h78) m_en[63:32] = m_en[63:32] | d;
    if (a == 8'h80) m_en[31:0]  = m_en[31:0]  & ~d;
    if (a == 8'h88) m_en[63:32] = m_en[63:32] & ~d;
    if (a >= 8'h10 && a <= 8'h48 && a[2:0] == 3'd0)
      m_prio[(a - 8'h10) * 4 +: 32] = d;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  // expected winner: strict ">" over ascending index keeps lowest on tie
  task automatic model(output bit f, output logic [3:0] lv, output logic [11:0] cd);
    logic [3:0] best;
    int idx;
    best = '0; idx = 0; f = 1'b0;
    for (int i = 0; i < 64; i++) begin
      if (irq_i[i] && m_en[i] && m_prio[i*4 +: 4] > best) begin
        best = m_prio[i*4 +: 4]; idx = i; f = 1'b1;
      end
    end
    lv = f ? best : 4'd0;
    cd = f ? 12'((8'h12 + idx) * 32) : 12'd0;
  endtask

  task automatic check_out(input string req);
    bit f; logic [3:0] lv; logic [11:0] cd;
    model(f, lv, cd);
    check(irq_o == f, req, 64'(irq_o), 64'(f));
    check(level_o == lv, req, 64'(level_o), 64'(lv));
    check(vec_o == cd, req, 64'(vec_o), 64'(cd));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual 0x1 expected 0x0");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240517));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(irq_o == 1'b0, "R1", 64'(irq_o), 64'd0);
    rd(8'h70, d); check(d == 0, "R1", 64'(d), 64'd0);
    rd(8'h38, d); check(d == 0, "R1", 64'(d), 64'd0);
    rd(8'h00, d); check(d == 0, "R1", 64'(d), 64'd0);

    // R2 enable set leaves other lines alone
    wr(8'h70, 32'h0000_00F0);
    wr(8'h70, 32'h0000_0001);
    rd(8'h70, d); check(d == 32'hF1, "R2", 64'(d), 64'hF1);
    wr(8'h78, 32'h8000_0000);
    rd(8'h78, d); check(d == 32'h8000_0000, "R2", 64'(d), 64'h8000_0000);
    rd(8'h70, d); check(d == 32'hF1, "R2", 64'(d), 64'hF1);

    // R3 disable clears selected lines, all-ones clears the bank
    wr(8'h80, 32'h0000_0010);
    rd(8'h70, d); check(d == 32'hE1, "R3", 64'(d), 64'hE1);
    wr(8'h88, 32'hFFFF_FFFF);
    rd(8'h78, d); check(d == 0, "R3", 64'(d), 64'd0);
    rd(8'h80, d); check(d == 0, "R3", 64'(d), 64'd0);

    // R4 mode set / clear aliases
    wr(8'h00, 32'h1);
    rd(8'h00, d); check(d == 1, "R4", 64'(d), 64'd1);
    rd(8'h08, d); check(d == 1, "R4", 64'(d), 64'd1);
    wr(8'h08, 32'h0);
    rd(8'h00, d); check(d == 1, "R4", 64'(d), 64'd1);
    wr(8'h08, 32'h1);
    rd(8'h08, d); check(d == 0, "R4", 64'(d), 64'd0);

    // R5 priority register layout
    wr(8'h18, 32'h7654_3210);
    rd(8'h18, d); check(d == 32'h7654_3210, "R5", 64'(d), 64'h7654_3210);
    wr(8'h78, 32'hFFFF_FFFF); wr(8'h70, 32'hFFFF_FFFF);
    irq_i = 64'd1 << 9; settle();
    check(level_o == 4'd1, "R5", 64'(level_o), 64'd1);
    irq_i = 64'd1 << 15; settle();
    check(level_o == 4'd7, "R5", 64'(level_o), 64'd7);

    // R7 priority zero never wins (line 8 has field 0)
    irq_i = 64'd1 << 8; settle();
    check(irq_o == 1'b0, "R7", 64'(irq_o), 64'd0);

    // R6 status readback with a partial enable mask
    wr(8'h80, 32'hFFFF_0000);
    irq_i = 64'hA5A5_0000_1234_5678; settle();
    rd(8'h50, d); check(d == 32'h1234_5678, "R6", 64'(d), 64'h1234_5678);
    rd(8'h58, d); check(d == 32'hA5A5_0000, "R6", 64'(d), 64'hA5A5_0000);
    rd(8'h60, d); check(d == 32'h0000_5678, "R6", 64'(d), 64'h5678);

    // R8 tie between lines 20 and 22 -> line 20
    wr(8'h20, 32'h0505_0500); irq_i = (64'd1 << 20) | (64'd1 << 22);
    wr(8'h70, 32'hFFFF_FFFF); settle();
    check(vec_o == 12'((8'h12 + 20) * 32), "R8", 64'(vec_o), 64'((8'h12 + 20) * 32));
    // R8 masked higher priority line does not win
    wr(8'h10, 32'h0000_000F); irq_i = irq_i | 64'd1; wr(8'h80, 32'h1); settle();
    check(level_o == 4'd5, "R8", 64'(level_o), 64'd5);

    // R9 highest line code
    wr(8'h48, 32'h9000_0000); irq_i = 64'd1 << 63; settle();
    check(vec_o == 12'hA20, "R9", 64'(vec_o), 64'hA20);
    check(level_o == 4'd9, "R9", 64'(level_o), 64'd9);

    // R10 cycle timing: latch edge, then output edge
    irq_i = '0; settle();
    check(irq_o == 1'b0, "R10", 64'(irq_o), 64'd0);
    @(negedge clk); irq_i = 64'd1 << 63;
    @(negedge clk); check(irq_o == 1'b0, "R10", 64'(irq_o), 64'd0);
    @(negedge clk); check(irq_o == 1'b1, "R10", 64'(irq_o), 64'd1);

    // R11 read data changes only at the sampling edge
    @(negedge clk); bus_re = 1'b1; bus_addr = 8'h48;
    #1 check(bus_rdata != 32'h9000_0000, "R11", 64'(bus_rdata), 64'h0);
    @(negedge clk); bus_re = 1'b0; bus_addr = 8'h00;
    check(bus_rdata == 32'h9000_0000, "R11", 64'(bus_rdata), 64'h9000_0000);
    @(negedge clk);
    check(bus_rdata == 32'h9000_0000, "R11", 64'(bus_rdata), 64'h9000_0000);

    // Random: R8 R9 R10 against the bench model
    for (int it = 0; it < 300; it++) begin
      int sel;
      sel = $urandom_range(0, 3);
      if (sel == 0) wr(8'h70 + 8'(8 * $urandom_range(0, 1)), $urandom & $urandom);
      if (sel == 1) wr(8'h80 + 8'(8 * $urandom_range(0, 1)), $urandom & $urandom);
      if (sel >= 2) wr(8'h10 + 8'(8 * $urandom_range(0, 7)), $urandom);
      irq_i = {$urandom & $urandom, $urandom & $urandom};
      settle();
      check_out("R8/R9/R10 random");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule